// File: doc/BRIEF.md
# Scaled Index Address Generator

This block forms a byte address for a load or store from three parts: a base value, an index value multiplied by a power of two, and a signed displacement. A two-bit form select picks the addressing variant. The variants are base plus scaled index, scaled index alone with no base, displacement relative to the instruction pointer, and base alone. A mode input selects either a 32-bit or a 64-bit address space.

The caller presents all operands together with a one-cycle request strobe. The block adds them, limits the sum to the active width, and registers the result. One clock later the address appears on the output together with a one-cycle valid pulse. Between requests the address output keeps its last value.

Top module: `sia_agen`

## Requirements
- R1: After reset `valid_o` is 0 and `addr_o` is 0. `valid_o` is 1 in exactly the cycle after a cycle with `req_i` high, and 0 otherwise.
- R2: With `form_i` = 00, the address is base + (index × scale) + displacement.
- R3: `scale_i` selects the index multiplier: 00 gives ×1, 01 gives ×2, 10 gives ×4 and 11 gives ×8.
- R4: With `form_i` = 01, the address is (index × scale) + displacement, and `base_i` has no effect.
- R5: With `form_i` = 10, the address is `ip_i` + displacement, and `base_i`, `index_i` and `scale_i` have no effect.
- R6: With `form_i` = 11, the address is base + displacement, and `index_i` and `scale_i` have no effect.
- R7: `disp_i` is a 32-bit two's-complement value and is sign-extended to the active width before the addition.
- R8: With `wide_i` = 0, only bits 31:0 of each operand are used. The sum wraps modulo 2^32, and `addr_o[63:32]` is 0.
- R9: With `wide_i` = 1, all 64 operand bits are used and the sum wraps modulo 2^64.
- R10: In a cycle with `req_i` low, `addr_o` keeps its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; operands are sampled in this cycle |
| wide_i | input | 1 | 1 selects the 64-bit address space, 0 the 32-bit space |
| form_i | input | 2 | Addressing form: 00 base+index, 01 index only, 10 IP-relative, 11 base only |
| scale_i | input | 2 | Index multiplier code |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| ip_i | input | 64 | Instruction pointer value |
| disp_i | input | 32 | Signed displacement |
| addr_o | output | 64 | Registered effective address |
| valid_o | output | 1 | One-cycle pulse marking a new address |

## Verification
Two things can happen in the same clock edge: the registered output of one request is being shown while the next request is being captured. The bench provokes this with requests on two consecutive cycles that use different forms and widths, a 64-bit IP-relative request followed by a 32-bit wrapping one. It judges the result by checking that `valid_o` stays high for both cycles and that each cycle shows the address of its own request. A second overlap is width narrowing while the upper operand bits are set. Table rows with nonzero upper bits in 32-bit mode check that those bits never reach `addr_o`.

// File: rtl/sia_pkg.sv
package sia_pkg;

    localparam int SIA_AW = 64;   // full address width
    localparam int SIA_NW = 32;   // narrow address width
    localparam int SIA_DW = 32;   // displacement width
    localparam int SIA_SW = 2;    // scale code width

    typedef enum logic [1:0] {
        FORM_BASE_IDX  = 2'b00,
        FORM_IDX_ONLY  = 2'b01,
        FORM_IP_REL    = 2'b10,
        FORM_BASE_ONLY = 2'b11
    } sia_form_e;

    typedef struct packed {
        logic              valid;
        logic [SIA_AW-1:0] addr;
    } sia_state_t;

endpackage

// File: rtl/sia_scale.sv
module sia_scale #(
    parameter int AW = 64,
    parameter int SW = 2
) (
    input  logic [AW-1:0] idx_i,
    input  logic [SW-1:0] code_i,
    output logic [AW-1:0] scaled_o
);
    localparam int NCODE = 1 << SW;

    logic [AW-1:0] cand [NCODE];

    for (genvar k = 0; k < NCODE; k++) begin : g_shift
        assign cand[k] = idx_i << k;
    end

    assign scaled_o = cand[code_i];

endmodule

// File: rtl/sia_opnd.sv
module sia_opnd #(
    parameter int AW = 64,
    parameter int NW = 32,
    parameter int DW = 32
) (
    input  logic          wide_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [AW-1:0] ip_i,
    input  logic [DW-1:0] disp_i,
    output logic [AW-1:0] mask_o,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] index_o,
    output logic [AW-1:0] ip_o,
    output logic [AW-1:0] disp_o
);
    localparam int EXT = AW - DW;
    localparam int HI  = AW - NW;

    logic [AW-1:0] narrow_mask;
    logic [AW-1:0] disp_ext;

    assign narrow_mask = {{HI{1'b0}}, {NW{1'b1}}};
    assign disp_ext    = {{EXT{disp_i[DW-1]}}, disp_i};

    always_comb begin
        mask_o  = wide_i ? {AW{1'b1}} : narrow_mask;
        base_o  = base_i  & mask_o;
        index_o = index_i & mask_o;
        ip_o    = ip_i    & mask_o;
        disp_o  = disp_ext & mask_o;
    end

endmodule

// File: rtl/sia_sum.sv
module sia_sum #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    input  logic [AW-1:0] c_i,
    input  logic [AW-1:0] mask_i,
    output logic [AW-1:0] sum_o
);
    logic [AW-1:0] raw;

    assign raw   = a_i + b_i + c_i;
    assign sum_o = raw & mask_i;

endmodule

// File: rtl/sia_agen.sv
module sia_agen
    import sia_pkg::*;
#(
    parameter int AW = SIA_AW,
    parameter int NW = SIA_NW,
    parameter int DW = SIA_DW,
    parameter int SW = SIA_SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          wide_i,
    input  logic [1:0]    form_i,
    input  logic [SW-1:0] scale_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [AW-1:0] ip_i,
    input  logic [DW-1:0] disp_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o
);
    logic [AW-1:0] mask;
    logic [AW-1:0] base_m;
    logic [AW-1:0] index_m;
    logic [AW-1:0] ip_m;
    logic [AW-1:0] disp_m;
    logic [AW-1:0] index_s;
    logic [AW-1:0] op_a;
    logic [AW-1:0] op_b;
    logic [AW-1:0] sum;

    sia_state_t st_d;
    sia_state_t st_q;

    sia_opnd #(.AW(AW), .NW(NW), .DW(DW)) u_opnd (
        .wide_i  (wide_i),
        .base_i  (base_i),
        .index_i (index_i),
        .ip_i    (ip_i),
        .disp_i  (disp_i),
        .mask_o  (mask),
        .base_o  (base_m),
        .index_o (index_m),
        .ip_o    (ip_m),
        .disp_o  (disp_m)
    );

    sia_scale #(.AW(AW), .SW(SW)) u_scale (
        .idx_i    (index_m),
        .code_i   (scale_i),
        .scaled_o (index_s)
    );

    // Operand selection per addressing form
    always_comb begin
        op_a = '0;
        op_b = '0;
        unique case (sia_form_e'(form_i))
            FORM_BASE_IDX: begin
                op_a = base_m;
                op_b = index_s;
            end
            FORM_IDX_ONLY: begin
                op_a = '0;
                op_b = index_s;
            end
            FORM_IP_REL: begin
                op_a = ip_m;
                op_b = '0;
            end
            FORM_BASE_ONLY: begin
                op_a = base_m;
                op_b = '0;
            end
            default: begin
                op_a = '0;
                op_b = '0;
            end
        endcase
    end

    sia_sum #(.AW(AW)) u_sum (
        .a_i    (op_a),
        .b_i    (op_b),
        .c_i    (disp_m),
        .mask_i (mask),
        .sum_o  (sum)
    );

    // Next-state computation
    always_comb begin
        st_d       = st_q;
        st_d.valid = req_i;
        if (req_i) begin
            st_d.addr = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/sia_agen_chk.sv
module sia_agen_chk #(
    parameter int AW = 64,
    parameter int NW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          wide_i,
    input logic [1:0]    form_i,
    input logic [AW-1:0] base_i,
    input logic [31:0]   disp_i,
    input logic [AW-1:0] addr_o,
    input logic          valid_o
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o) else $error("valid missing after request"); // R1

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o) else $error("valid without request"); // R1

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wide_i) |=> (addr_o[AW-1:NW] == '0)) else $error("upper bits set in narrow mode"); // R8

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(addr_o)) else $error("address moved while idle"); // R10

    AST_BASE_ONLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wide_i && form_i == 2'b11 && disp_i == 32'd0) |=> (addr_o == $past(base_i)))
        else $error("base-only form with zero displacement altered base"); // R6

endmodule

bind sia_agen sia_agen_chk #(.AW(AW), .NW(NW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .wide_i  (wide_i),
    .form_i  (form_i),
    .base_i  (base_i),
    .disp_i  (disp_i),
    .addr_o  (addr_o),
    .valid_o (valid_o)
);

// File: tb/sia_agen_tb.sv
`timescale 1ns/1ps
module sia_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [1:0]  form_i = 2'b00;
    logic [1:0]  scale_i = 2'b00;
    logic [63:0] base_i = '0;
    logic [63:0] index_i = '0;
    logic [63:0] ip_i = '0;
    logic [31:0] disp_i = '0;
    logic [63:0] addr_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sia_agen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .wide_i  (wide_i),
        .form_i  (form_i),
        .scale_i (scale_i),
        .base_i  (base_i),
        .index_i (index_i),
        .ip_i    (ip_i),
        .disp_i  (disp_i),
        .addr_o  (addr_o),
        .valid_o (valid_o)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic        wide;
        logic [1:0]  form;
        logic [1:0]  scale;
        logic [63:0] base;
        logic [63:0] index;
        logic [63:0] ip;
        logic [31:0] disp;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R2 x1
        '{8'd2, 1'b1, 2'b00, 2'b00, 64'h1000, 64'h5, 64'h0, 32'h0, 64'h1005},
        // R3 x2
        '{8'd3, 1'b1, 2'b00, 2'b01, 64'h2000, 64'h3, 64'h0, 32'h0, 64'h2006},
        // R3 x4 with displacement
        '{8'd3, 1'b1, 2'b00, 2'b10, 64'h2000, 64'h3, 64'h0, 32'h10, 64'h201C},
        // R3 x8
        '{8'd3, 1'b1, 2'b00, 2'b11, 64'h0, 64'h10, 64'h0, 32'h0, 64'h80},
        // R7 negative displacement
        '{8'd7, 1'b1, 2'b00, 2'b00, 64'h100, 64'h0, 64'h0, 32'hFFFFFFF0, 64'hF0},
        // R4 base ignored
        '{8'd4, 1'b1, 2'b01, 2'b10, 64'hDEAD, 64'h7, 64'h0, 32'h0, 64'h1C},
        // R5 base and index ignored
        '{8'd5, 1'b1, 2'b10, 2'b11, 64'h55, 64'h66, 64'h1_0000_0000, 32'h22, 64'h1_0000_0022},
        // R5 negative offset
        '{8'd5, 1'b1, 2'b10, 2'b00, 64'h0, 64'h0, 64'h1000, 32'hFFFFFFFC, 64'hFFC},
        // R6 index and scale ignored
        '{8'd6, 1'b1, 2'b11, 2'b11, 64'h4000, 64'hFFFF, 64'h0, 32'h8, 64'h4008},
        // R8 32-bit wrap
        '{8'd8, 1'b0, 2'b00, 2'b00, 64'hFFFF_FFFF, 64'h2, 64'h0, 32'h0, 64'h1},
        // R8 upper operand bits dropped
        '{8'd8, 1'b0, 2'b00, 2'b01, 64'hABCD_0000_0000_0010, 64'h1234_0000_0000_0001, 64'h0, 32'h0, 64'h12},
        // R8 narrow IP-relative with negative displacement
        '{8'd8, 1'b0, 2'b10, 2'b00, 64'h0, 64'h0, 64'h5_0000_0008, 32'hFFFFFFF0, 64'hFFFF_FFF8},
        // R9 64-bit wrap
        '{8'd9, 1'b1, 2'b00, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 32'h1, 64'h1},
        // R9 scaled index overflows 64 bits
        '{8'd9, 1'b1, 2'b01, 2'b11, 64'h0, 64'h2000_0000_0000_0000, 64'h0, 32'h0, 64'h0},
        // R9 carry past bit 31
        '{8'd9, 1'b1, 2'b00, 2'b00, 64'h8000_0000, 64'h8000_0000, 64'h0, 32'h0, 64'h1_0000_0000},
        // R4 narrow index-only wrap
        '{8'd4, 1'b0, 2'b01, 2'b10, 64'h9999, 64'h4000_0001, 64'h0, 32'h0, 64'h4}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        wide_i  = v.wide;
        form_i  = v.form;
        scale_i = v.scale;
        base_i  = v.base;
        index_i = v.index;
        ip_i    = v.ip;
        disp_i  = v.disp;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        vec_t v;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {63'd0, valid_o}, 64'd0);
        check("R1 reset addr", addr_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            check($sformatf("R1 valid row %0d", i), {63'd0, valid_o}, 64'd1);
            check($sformatf("R%0d addr row %0d", VECS[i].rq, i), addr_o, VECS[i].exp);
        end

        // R1 valid drops after a single request
        @(negedge clk);
        check("R1 valid low when idle", {63'd0, valid_o}, 64'd0);

        // R10 hold: change all inputs without a request
        held = addr_o;
        v = VECS[0];
        v.base = 64'h7777;
        drive(v);
        @(negedge clk);
        @(negedge clk);
        check("R10 addr held", addr_o, held);
        check("R10 valid low", {63'd0, valid_o}, 64'd0);

        // Back-to-back: 64-bit IP-relative then 32-bit wrap (R5, R8)
        drive(VECS[6]);
        req_i = 1'b1;
        @(negedge clk);
        check("R5 b2b first addr", addr_o, 64'h1_0000_0022);
        check("R1 b2b first valid", {63'd0, valid_o}, 64'd1);
        drive(VECS[9]);
        @(negedge clk);
        req_i = 1'b0;
        check("R8 b2b second addr", addr_o, 64'h1);
        check("R1 b2b second valid", {63'd0, valid_o}, 64'd1);

        // R6 scale code change has no effect in base-only form
        v = VECS[8];
        v.scale = 2'b00;
        v.index = 64'h1234;
        drive(v);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check("R6 index/scale ignored", addr_o, 64'h4008);

        // R1 reset mid-stream clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears addr", addr_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule